// File: doc/BRIEF.md
# Key-Stepped Two-Colour Dot Matrix Display

The block drives an 8x8 LED matrix that has a red and a green LED behind every dot. It shows one glyph at a time out of a small built-in table. The rows are lit one after another, fast enough that the whole glyph looks steady. For the row that is lit, the block drives a red column word and a green column word. A dot that is set in both words shows the mixed colour.

A raw mechanical push-button selects the glyph. The button is first synchronised to the clock. It then passes a stability filter, and finally an edge detector that fires only on the press. Each clean press moves the glyph index on by one, and the index wraps from the last table entry back to the first.

Reset is asynchronous and active low, and its release is synchronous. While reset is low, every column is dark and no row is selected.

Top module: `dm_matrix_top`

## Requirements
- R1: Outside reset, `row_sel_n` has exactly one bit low. Bit r low (value `~(1<<r)`) selects row r, so row 0 is 8'hFE and row 7 is 8'h7F.
- R2: Rows are selected in the order 0,1,...,7 and then row 0 again. Each row stays selected for exactly `SCAN_DIV` clock cycles.
- R3: While row r is selected, `red_col` and `grn_col` carry byte r (bits 8r+7..8r) of that glyph's red and green 64-bit planes. Column bits are active high. The planes are, as red/green: glyph 0 = 64'h81818199_99A5C381 / 0; glyph 1 = 0 / 64'h66FFFFFF_7E3C1800; glyph 2 = 64'hFF818181_818181FF / the same; glyph 3 = 64'h80402010_08040201 / 64'h01020408_10204080; glyph 4 = 64'hAA55AA55_AA55AA55 / 64'h55AA55AA_55AA55AA; glyph 5 = 0 / 64'h183C7EFF_18181818; glyph 6 = 64'h3C42A581_A599423C / 0.
- R4: One button press moves the displayed glyph on by exactly one index. A press is the input held high for at least `DEB_TICKS` cycles and then released for at least `DEB_TICKS` cycles.
- R5: With `NUM_GLYPHS` = 7, the index takes the values 0 to 6 and goes from 6 back to 0.
- R6: A button level that does not last `DEB_TICKS` consecutive cycles, such as contact bounce, does not change the glyph.
- R7: Holding the button down gives exactly one step, and releasing it gives none.
- R8: While `rst_n` is low, `red_col` and `grn_col` are 0 and `row_sel_n` is 8'hFF. After release, glyph 0 is shown, starting at row 0.
- R9: Glyph 0 is the letter W in red. Its green plane is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Unfiltered push-button level, high while pressed |
| red_col | output | 8 | Red column drive for the selected row, active high |
| grn_col | output | 8 | Green column drive for the selected row, active high |
| row_sel_n | output | 8 | Row select, active-low one-hot |

## Verification
The bench builds the block with `DEB_TICKS` = 8 and `SCAN_DIV` = 4. The defaults are about 20 ms of filtering and a slow row rate, far too long to simulate. With the short values, many presses, a full wrap of the glyph index and bounce bursts just shorter than the filter window all fit in a short run. The short scan divider shows every row of each glyph many times, so all 112 row words can be compared and the exact row dwell can be measured.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int unsigned ROWS = 8;
  localparam int unsigned COLS = 8;
  localparam int unsigned TABLE_GLYPHS = 7;

  typedef logic [COLS-1:0]      col_t;
  typedef logic [ROWS*COLS-1:0] plane_t;

  typedef struct packed {
    plane_t red;
    plane_t grn;
  } glyph_t;

  // Built-in glyph art; byte r of a plane is row r, bit c is column c.
  function automatic glyph_t glyph_lookup(input logic [2:0] idx);
    glyph_t g;
    g = '0;
    case (idx)
      3'd0: g.red = 64'h81818199_99A5C381;                      // letter W
      3'd1: g.grn = 64'h66FFFFFF_7E3C1800;                      // heart
      3'd2: begin
        g.red = 64'hFF818181_818181FF;                          // frame
        g.grn = 64'hFF818181_818181FF;
      end
      3'd3: begin
        g.red = 64'h80402010_08040201;                          // cross
        g.grn = 64'h01020408_10204080;
      end
      3'd4: begin
        g.red = 64'hAA55AA55_AA55AA55;                          // checker
        g.grn = 64'h55AA55AA_55AA55AA;
      end
      3'd5: g.grn = 64'h183C7EFF_18181818;                      // up arrow
      3'd6: g.red = 64'h3C42A581_A599423C;                      // face
      default: g = '0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/dm_debounce.sv
module dm_debounce #(
  parameter int unsigned STABLE_TICKS = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_out
);
  localparam int unsigned CW = $clog2(STABLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic          sync_q1, sync_q2;
  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // two-stage synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= raw_in;
      sync_q2 <= sync_q1;
    end
  end

  // stability filter: adopt the new level after STABLE_TICKS differing cycles
  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    if (sync_q2 != level_q) begin
      if (cnt_q == LAST) begin
        level_d = sync_q2;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_out = level_q;
endmodule

// File: rtl/dm_press_edge.sv
module dm_press_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic press_pulse
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  assign press_pulse = level_in & ~prev_q;
endmodule

// File: rtl/dm_row_scan.sv
module dm_row_scan #(
  parameter int unsigned SCAN_DIV = 12_500,
  parameter int unsigned ROWS     = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [$clog2(ROWS)-1:0] row_idx
);
  localparam int unsigned PW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam int unsigned RW = $clog2(ROWS);
  localparam logic [PW-1:0] PLAST = PW'(SCAN_DIV - 1);
  localparam logic [RW-1:0] RLAST = RW'(ROWS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [RW-1:0] row_q, row_d;
  logic          scan_en;

  always_comb begin
    scan_en = (pre_q == PLAST);
    pre_d   = scan_en ? '0 : pre_q + 1'b1;
    row_d   = row_q;
    if (scan_en) row_d = (row_q == RLAST) ? '0 : row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      row_q <= '0;
    end else begin
      pre_q <= pre_d;
      if (scan_en) row_q <= row_d;
    end
  end

  assign row_idx = row_q;
endmodule

// File: rtl/dm_glyph_rom.sv
module dm_glyph_rom
  import dm_pkg::*;
#(
  parameter int unsigned IW = 3
) (
  input  logic [IW-1:0] glyph_idx,
  input  logic [2:0]    row_idx,
  output col_t          red_word,
  output col_t          grn_word
);
  glyph_t g;

  always_comb begin
    g        = glyph_lookup(3'(glyph_idx));
    red_word = g.red[row_idx*COLS +: COLS];
    grn_word = g.grn[row_idx*COLS +: COLS];
  end
endmodule

// File: rtl/dm_matrix_top.sv
module dm_matrix_top
  import dm_pkg::*;
#(
  parameter int unsigned DEB_TICKS  = 2_000_000,
  parameter int unsigned SCAN_DIV   = 12_500,
  parameter int unsigned NUM_GLYPHS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_raw,
  output logic [7:0] red_col,
  output logic [7:0] grn_col,
  output logic [7:0] row_sel_n
);
  localparam int unsigned IW = $clog2(NUM_GLYPHS);
  localparam logic [IW-1:0] GLAST = IW'(NUM_GLYPHS - 1);

  logic          btn_level;
  logic          step_pulse;
  logic [2:0]    row_idx;
  logic [IW-1:0] glyph_idx, glyph_d;
  col_t          red_w, grn_w;
  col_t          red_q, grn_q, row_q;
  col_t          row_d;

  dm_debounce #(.STABLE_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .raw_in(btn_raw), .level_out(btn_level)
  );

  dm_press_edge u_edge (
    .clk(clk), .rst_n(rst_n), .level_in(btn_level), .press_pulse(step_pulse)
  );

  dm_row_scan #(.SCAN_DIV(SCAN_DIV), .ROWS(ROWS)) u_scan (
    .clk(clk), .rst_n(rst_n), .row_idx(row_idx)
  );

  dm_glyph_rom #(.IW(IW)) u_rom (
    .glyph_idx(glyph_idx), .row_idx(row_idx), .red_word(red_w), .grn_word(grn_w)
  );

  // glyph index: one step per press pulse, wrapping at the table end
  always_comb begin
    glyph_d = (glyph_idx == GLAST) ? '0 : glyph_idx + 1'b1;
    row_d   = ~(col_t'(1) << row_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glyph_idx <= '0;
    else if (step_pulse) glyph_idx <= glyph_d;
  end

  // registered drive; dark and deselected while in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_q <= '0;
      grn_q <= '0;
      row_q <= '1;
    end else begin
      red_q <= red_w;
      grn_q <= grn_w;
      row_q <= row_d;
    end
  end

  assign red_col   = red_q;
  assign grn_col   = grn_q;
  assign row_sel_n = row_q;
endmodule

// File: rtl/dm_matrix_chk.sv
module dm_matrix_chk #(
  parameter int unsigned NUM_GLYPHS = 7,
  parameter int unsigned IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    row_sel_n,
  input logic [IW-1:0] glyph_idx,
  input logic          step_pulse
);
  // R1: one row low once the first row has been driven
  a_r1_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (row_sel_n != 8'hFF) |-> $countones(~row_sel_n) == 1);

  // R2: a row change moves to the next row up
  a_r2_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(row_sel_n) != 8'hFF) && (row_sel_n != $past(row_sel_n))
    |-> row_sel_n == {$past(row_sel_n[6:0]), $past(row_sel_n[7])});

  // R4: the index only moves after a press pulse, by one step
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (glyph_idx != $past(glyph_idx)) |-> $past(step_pulse) &&
    (glyph_idx == (($past(glyph_idx) == IW'(NUM_GLYPHS - 1)) ? '0 : $past(glyph_idx) + 1'b1)));

  // R5: index stays inside the table
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(glyph_idx) < NUM_GLYPHS);

  // R7: a press pulse lasts one cycle
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);
endmodule

bind dm_matrix_top dm_matrix_chk #(.NUM_GLYPHS(NUM_GLYPHS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_sel_n(row_sel_n),
  .glyph_idx(glyph_idx), .step_pulse(step_pulse)
);

// File: tb/tb_dm_matrix_top.sv
`timescale 1ns/1ps
module tb_dm_matrix_top;
  localparam int DEB = 8;
  localparam int DIV = 4;
  localparam int NV  = 7;
  localparam int PRESSES [NV] = '{1, 1, 2, 2, 1, 3, 4};
  localparam int EXPECT  [NV] = '{1, 2, 4, 6, 0, 3, 0};

  logic       clk, rst_n, btn_raw;
  logic [7:0] red_col, grn_col, row_sel_n;
  int         checks, fails, cyc;
  bit         done;

  dm_matrix_top #(.DEB_TICKS(DEB), .SCAN_DIV(DIV), .NUM_GLYPHS(7)) dut (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw),
    .red_col(red_col), .grn_col(grn_col), .row_sel_n(row_sel_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] planes(input int g);
    case (g)
      0: return {64'h81818199_99A5C381, 64'h0};
      1: return {64'h0, 64'h66FFFFFF_7E3C1800};
      2: return {64'hFF818181_818181FF, 64'hFF818181_818181FF};
      3: return {64'h80402010_08040201, 64'h01020408_10204080};
      4: return {64'hAA55AA55_AA55AA55, 64'h55AA55AA_55AA55AA};
      5: return {64'h0, 64'h183C7EFF_18181818};
      6: return {64'h3C42A581_A599423C, 64'h0};
      default: return '0;
    endcase
  endfunction

  task automatic result(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic press(input int high_cycles);
    @(posedge clk); btn_raw <= 1'b1;
    repeat (high_cycles) @(posedge clk);
    btn_raw <= 1'b0;
    repeat (DEB + 6) @(posedge clk);
  endtask

  // watch two full frames; every sampled row word must match glyph g
  task automatic check_glyph(input int g, input string req);
    logic [127:0] p;
    logic [7:0]   seen;
    int           bad;
    logic [15:0]  act, exp;
    p = planes(g); seen = '0; bad = 0; act = '0; exp = '0;
    for (int k = 0; k < 16 * DIV; k++) begin
      @(negedge clk);
      if ($countones(~row_sel_n) != 1) begin
        bad++; act = {8'h00, row_sel_n}; exp = 16'h0;
      end else begin
        for (int r = 0; r < 8; r++) begin
          if (!row_sel_n[r]) begin
            seen[r] = 1'b1;
            if ({red_col, grn_col} != {p[64 + r*8 +: 8], p[r*8 +: 8]}) begin
              bad++; act = {red_col, grn_col};
              exp = {p[64 + r*8 +: 8], p[r*8 +: 8]};
            end
          end
        end
      end
    end
    result(bad == 0 && seen == 8'hFF, req, $sformatf("glyph %0d rows", g),
           64'(act), 64'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int t0, t1;
    logic [7:0] r0, r1;
    checks = 0; fails = 0; cyc = 0; done = 0;
    btn_raw = 1'b0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    result(red_col == 0 && grn_col == 0 && row_sel_n == 8'hFF, "R8", "reset drive",
           64'({red_col, grn_col, row_sel_n}), 64'h0000FF);
    rst_n = 1'b1;
    @(negedge clk);
    result(row_sel_n == 8'hFE, "R8", "first row after reset", 64'(row_sel_n), 64'hFE);
    check_glyph(0, "R9");

    // R2: dwell and order
    @(negedge clk); r0 = row_sel_n;
    while (row_sel_n == r0) @(negedge clk);
    t0 = cyc; r0 = row_sel_n;
    while (row_sel_n == r0) @(negedge clk);
    t1 = cyc; r1 = row_sel_n;
    result(t1 - t0 == DIV, "R2", "row dwell", 64'(t1 - t0), 64'(DIV));
    result(r1 == {r0[6:0], r0[7]}, "R2", "row order", 64'(r1), 64'({r0[6:0], r0[7]}));

    // vector table: presses then expected glyph (R3, R4, R5)
    for (int v = 0; v < NV; v++) begin
      for (int n = 0; n < PRESSES[v]; n++) press(DEB + 6);
      check_glyph(EXPECT[v], (v == 4) ? "R5" : "R3/R4");
    end

    // R6: bounce bursts shorter than the filter window
    for (int b = 0; b < 5; b++) begin
      @(posedge clk); btn_raw <= 1'b1;
      repeat (DEB - 2) @(posedge clk);
      btn_raw <= 1'b0;
      repeat (2) @(posedge clk);
    end
    repeat (DEB + 6) @(posedge clk);
    check_glyph(0, "R6");

    // R7: long hold gives one step, release gives none
    @(posedge clk); btn_raw <= 1'b1;
    repeat (DEB * 10) @(posedge clk);
    check_glyph(1, "R7");
    btn_raw <= 1'b0;
    repeat (DEB * 3) @(posedge clk);
    check_glyph(1, "R7");

    // R8: reset mid-run returns to glyph 0
    press(DEB + 6);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    result(red_col == 0 && grn_col == 0 && row_sel_n == 8'hFF, "R8", "mid-run reset",
           64'({red_col, grn_col, row_sel_n}), 64'h0000FF);
    rst_n = 1'b1;
    check_glyph(0, "R8");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule